// File: doc/BRIEF.md
# SDRAM Initialisation and Refresh Sequencer

This block drives the SDRAM command bus from reset until the memory is ready. It then keeps the array refreshed for as long as the chip runs. Coming out of reset, it holds clock enable and every data mask high and issues only no-operation commands for a programmable power-up pause. It then precharges every bank and issues eight auto-refresh commands. Finally it writes the mode register from the configuration inputs and waits out the mode-write recovery time before it hands the bus to the access controller.

Once running, an interval counter marks one refresh as owed every refresh period. The owed count is capped at eight. The block raises `ref_req`, and it issues a refresh only when the access controller answers with `ref_gnt`. If several refreshes are owed, they go out back to back, each one a bank cycle time after the one before. Self refresh is requested with `sr_req`. Entry is a refresh command issued with clock enable low, and exit raises clock enable and then waits the exit recovery time. All timings are given in picoseconds and rounded up to whole clocks, except the refresh period, which is rounded down.

Top module: `sdram_refresh_seq`

## Requirements
- R1: From reset until the precharge, `sd_cke` is 1, every `sd_dqm` bit is 1, `init_done` and `acc_allow` are 0, and `sd_cmd` (= {cs_n, ras_n, cas_n, we_n}) is no-operation 4'b0111 for PWR_N = ceil(PWRUP_PS/CLK_PS) cycles counted from the first cycle with the synchronised reset released.
- R2: The first command is precharge-all, code 4'b0010 with address bit 10 set, issued in cycle PWR_N.
- R3: Eight auto-refresh commands, code 4'b0001, follow. The first is TRP_N cycles after the precharge, and each later one is TRC_N cycles after the one before it. TRP_N and TRC_N are the rounded-up clock counts, with a minimum of 2.
- R4: A mode-register write, code 4'b0000 with bank 0, is issued TRC_N cycles after the last initial refresh. Its address carries burst length code in bits 2:0, burst type in bit 3 (1 = interleaved), CAS latency in bits 6:4 and single-write mode in bit 9, with every other bit 0.
- R5: When the burst length code is 3'b111 (full page), bit 3 of the mode word is 0 even if interleaved type is requested.
- R6: `init_done` and `acc_allow` rise TMRD_CYC cycles after the mode-register write, and `sd_dqm` drops to 0 in the same cycle. `init_done` never falls again without a reset.
- R7: After `init_done`, one refresh becomes owed every REF_N = floor(REF_PERIOD_PS/CLK_PS) cycles. The first one is owed REF_N cycles after `init_done` rises. `ref_req` is high while a refresh is owed, while self refresh is requested, or while the block holds the bus.
- R8: A refresh after initialisation is issued only in the cycle after `ref_gnt` was seen high. Owed refreshes follow one another TRC_N cycles apart while the grant stays high.
- R9: At most eight refreshes are owed. With more missed intervals, exactly eight are issued once a grant arrives.
- R10: With `sr_req` and `ref_gnt` high and nothing owed, the block issues a refresh with `sd_cke` low in the next cycle. `sd_cke` stays low and `acc_allow` stays 0 while `sr_req` stays high.
- R11: The cycle after `sr_req` is seen low, `sd_cke` returns to 1 with no-operation. `acc_allow` returns TXSR_N cycles after that, and the refresh interval restarts from zero in that cycle.
- R12: `acc_allow` is high only while the block is idle after initialisation. While it is high, the block drives no-operation with `sd_cke` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_cas_lat | input | 3 | CAS latency written to mode bits 6:4 |
| cfg_burst_len | input | 3 | Burst length code written to mode bits 2:0 |
| cfg_interleave | input | 1 | Requests interleaved burst order |
| cfg_single_wr | input | 1 | Requests single-location writes (mode bit 9) |
| sr_req | input | 1 | Level request to enter and stay in self refresh |
| ref_gnt | input | 1 | Access controller has released the bus |
| ref_req | output | 1 | Sequencer needs or holds the bus |
| acc_allow | output | 1 | Access controller may drive commands |
| init_done | output | 1 | Power-up sequence complete |
| sd_cke | output | 1 | SDRAM clock enable |
| sd_cmd | output | 4 | {cs_n, ras_n, cas_n, we_n} |
| sd_addr | output | ADDR_W | Address bus |
| sd_ba | output | BA_W | Bank address |
| sd_dqm | output | DQM_W | Data masks |

## Verification
Some rules hold in every cycle, and the bound properties check those. Masks and grant stay blocked before initialisation, and `init_done` never falls. A precharge always carries bit 10 and a mode write never pairs full page with interleaved order. Each post-init refresh is preceded by a grant, a falling clock enable carries a refresh, and an allowed cycle is an idle one. Other behaviour appears only over a scenario, and the bench sweeps those. The exact issue cycles of the power-up sequence and the mode word are swept over every burst length, burst type, write mode and two latencies. The refresh pacing, the backlog drained back to back, the cap of eight and the restart of the interval after self-refresh exit are run as one long scenario.

// File: rtl/sdr_seq_pkg.sv
package sdr_seq_pkg;

  typedef enum logic [3:0] {
    CMD_MRS = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_NOP = 4'b0111
  } sdr_cmd_e;

  typedef enum logic [3:0] {
    S_PWRUP, S_PREA, S_PREA_W, S_IREF, S_IREF_W, S_MRS, S_MRS_W,
    S_IDLE, S_REF, S_REF_W, S_SR_IN, S_SR, S_SR_OUT, S_SR_W
  } seq_state_e;

  function automatic int ps_to_cyc_up(int ps, int clk_ps);
    return (ps + clk_ps - 1) / clk_ps;
  endfunction

  // gap of n cycles between two commands -> timer load value
  function automatic int gap_load(int n);
    return (n < 2) ? 0 : n - 2;
  endfunction

  function automatic int max_int(int a, int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sdr_wait_timer.sv
module sdr_wait_timer #(
  parameter int W       = 8,
  parameter int RST_VAL = 0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)               cnt_d = load_val;
    else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= W'(RST_VAL);
    else        cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/sdr_refresh_pacer.sv
module sdr_refresh_pacer #(
  parameter int INTERVAL = 2083,
  parameter int MAX_OWED = 8,
  localparam int TW = (INTERVAL > 1) ? $clog2(INTERVAL) : 1,
  localparam int OW = $clog2(MAX_OWED + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic clear,
  input  logic consume,
  output logic pending
);
  logic [TW-1:0] tick_q, tick_d;
  logic [OW-1:0] owed_q, owed_d;
  logic          tick;

  always_comb begin
    tick   = 1'b0;
    tick_d = tick_q;
    if (clear || !run) begin
      tick_d = '0;
    end else if (tick_q == TW'(INTERVAL - 1)) begin
      tick_d = '0;
      tick   = 1'b1;
    end else begin
      tick_d = tick_q + 1'b1;
    end
  end

  always_comb begin
    owed_d = owed_q;
    if (clear) begin
      owed_d = '0;
    end else if (tick && !consume) begin
      if (owed_q != OW'(MAX_OWED)) owed_d = owed_q + 1'b1;
    end else if (!tick && consume && owed_q != '0) begin
      owed_d = owed_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_q <= '0;
      owed_q <= '0;
    end else begin
      tick_q <= tick_d;
      owed_q <= owed_d;
    end
  end

  assign pending = (owed_q != '0);
endmodule

// File: rtl/sdr_mode_word.sv
module sdr_mode_word #(
  parameter int ADDR_W = 12
) (
  input  logic [2:0]        cas_lat,
  input  logic [2:0]        burst_len,
  input  logic              interleave,
  input  logic              single_wr,
  output logic [ADDR_W-1:0] word
);
  logic order_bit;

  // full page only supports sequential order
  assign order_bit = interleave && (burst_len != 3'b111);

  always_comb begin
    word      = '0;
    word[2:0] = burst_len;
    word[3]   = order_bit;
    word[6:4] = cas_lat;
    word[9]   = single_wr;
  end
endmodule

// File: rtl/sdram_refresh_seq.sv
module sdram_refresh_seq
  import sdr_seq_pkg::*;
#(
  parameter int CLK_PS        = 7500,
  parameter int PWRUP_PS      = 200_000_000,
  parameter int TRP_PS        = 20_000,
  parameter int TRC_PS        = 67_500,
  parameter int TXSR_PS       = 10_000,
  parameter int TMRD_CYC      = 2,
  parameter int REF_PERIOD_PS = 15_625_000,
  parameter int INIT_REFS     = 8,
  parameter int MAX_OWED      = 8,
  parameter int ADDR_W        = 12,
  parameter int BA_W          = 2,
  parameter int DQM_W         = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        cfg_cas_lat,
  input  logic [2:0]        cfg_burst_len,
  input  logic              cfg_interleave,
  input  logic              cfg_single_wr,
  input  logic              sr_req,
  input  logic              ref_gnt,
  output logic              ref_req,
  output logic              acc_allow,
  output logic              init_done,
  output logic              sd_cke,
  output logic [3:0]        sd_cmd,
  output logic [ADDR_W-1:0] sd_addr,
  output logic [BA_W-1:0]   sd_ba,
  output logic [DQM_W-1:0]  sd_dqm
);
  localparam int PWR_N    = max_int(ps_to_cyc_up(PWRUP_PS, CLK_PS), 1);
  localparam int PWR_LOAD = PWR_N - 1;
  localparam int TRP_LOAD = gap_load(ps_to_cyc_up(TRP_PS, CLK_PS));
  localparam int TRC_LOAD = gap_load(ps_to_cyc_up(TRC_PS, CLK_PS));
  localparam int TXS_LOAD = gap_load(ps_to_cyc_up(TXSR_PS, CLK_PS));
  localparam int MRD_LOAD = gap_load(TMRD_CYC);
  localparam int REF_N    = max_int(REF_PERIOD_PS / CLK_PS, 2);
  localparam int MAX_LOAD = max_int(max_int(PWR_LOAD, TRP_LOAD),
                            max_int(max_int(TRC_LOAD, TXS_LOAD), MRD_LOAD));
  localparam int TMR_W    = $clog2(MAX_LOAD + 2);
  localparam int IRW      = $clog2(INIT_REFS + 1);

  // reset: asynchronous assert, synchronous release
  logic rs1_q, rs2_q, rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rs2_q <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rs2_q <= rs1_q;
    end
  end
  assign rst_int_n = rs2_q;

  seq_state_e        state_q, state_d;
  logic [IRW-1:0]    iref_q, iref_d;
  logic              done_q, done_d;
  logic              tmr_load, tmr_zero;
  logic [TMR_W-1:0]  tmr_val;
  logic              owed, pace_clear, pace_consume;
  logic [ADDR_W-1:0] mode_word;

  sdr_wait_timer #(.W(TMR_W), .RST_VAL(PWR_LOAD)) i_timer (
    .clk(clk), .rst_n(rst_int_n), .load(tmr_load),
    .load_val(tmr_val), .zero(tmr_zero)
  );

  sdr_refresh_pacer #(.INTERVAL(REF_N), .MAX_OWED(MAX_OWED)) i_pacer (
    .clk(clk), .rst_n(rst_int_n), .run(done_q), .clear(pace_clear),
    .consume(pace_consume), .pending(owed)
  );

  sdr_mode_word #(.ADDR_W(ADDR_W)) i_mode (
    .cas_lat(cfg_cas_lat), .burst_len(cfg_burst_len),
    .interleave(cfg_interleave), .single_wr(cfg_single_wr), .word(mode_word)
  );

  // next state
  always_comb begin
    state_d  = state_q;
    iref_d   = iref_q;
    done_d   = done_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (state_q)
      S_PWRUP:  if (tmr_zero) state_d = S_PREA;
      S_PREA: begin
        tmr_load = 1'b1;
        tmr_val  = TMR_W'(TRP_LOAD);
        state_d  = S_PREA_W;
      end
      S_PREA_W: if (tmr_zero) state_d = S_IREF;
      S_IREF: begin
        tmr_load = 1'b1;
        tmr_val  = TMR_W'(TRC_LOAD);
        iref_d   = iref_q + 1'b1;
        state_d  = S_IREF_W;
      end
      S_IREF_W: if (tmr_zero) state_d = (iref_q == IRW'(INIT_REFS)) ? S_MRS : S_IREF;
      S_MRS: begin
        tmr_load = 1'b1;
        tmr_val  = TMR_W'(MRD_LOAD);
        state_d  = S_MRS_W;
      end
      S_MRS_W: if (tmr_zero) begin
        state_d = S_IDLE;
        done_d  = 1'b1;
      end
      S_IDLE: begin
        if (ref_gnt && owed)        state_d = S_REF;
        else if (ref_gnt && sr_req) state_d = S_SR_IN;
      end
      S_REF: begin
        tmr_load = 1'b1;
        tmr_val  = TMR_W'(TRC_LOAD);
        state_d  = S_REF_W;
      end
      S_REF_W:  if (tmr_zero) state_d = (owed && ref_gnt) ? S_REF : S_IDLE;
      S_SR_IN:  state_d = S_SR;
      S_SR:     if (!sr_req) state_d = S_SR_OUT;
      S_SR_OUT: begin
        tmr_load = 1'b1;
        tmr_val  = TMR_W'(TXS_LOAD);
        state_d  = S_SR_W;
      end
      S_SR_W:   if (tmr_zero) state_d = S_IDLE;
      default:  state_d = S_PWRUP;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q <= S_PWRUP;
      iref_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      iref_q  <= iref_d;
      done_q  <= done_d;
    end
  end

  logic in_sr;
  assign in_sr        = (state_q == S_SR_IN) || (state_q == S_SR) ||
                        (state_q == S_SR_OUT) || (state_q == S_SR_W);
  assign pace_clear   = in_sr;
  assign pace_consume = (state_q == S_REF);

  // outputs
  always_comb begin
    sd_cmd  = CMD_NOP;
    sd_addr = '0;
    unique case (state_q)
      S_PREA: begin
        sd_cmd      = CMD_PRE;
        sd_addr[10] = 1'b1;
      end
      S_IREF, S_REF, S_SR_IN: sd_cmd = CMD_REF;
      S_MRS: begin
        sd_cmd  = CMD_MRS;
        sd_addr = mode_word;
      end
      default: ;
    endcase
  end

  assign sd_ba     = '0;
  assign sd_cke    = !((state_q == S_SR_IN) || (state_q == S_SR));
  assign sd_dqm    = {DQM_W{!done_q}};
  assign init_done = done_q;
  assign acc_allow = (state_q == S_IDLE);
  assign ref_req   = ((state_q == S_IDLE) && (owed || sr_req)) ||
                     (state_q == S_REF) || (state_q == S_REF_W) || in_sr;
endmodule

// File: rtl/sdr_seq_chk.sv
module sdr_seq_chk
  import sdr_seq_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int BA_W   = 2,
  parameter int DQM_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ref_gnt,
  input logic              acc_allow,
  input logic              init_done,
  input logic              sd_cke,
  input logic [3:0]        sd_cmd,
  input logic [ADDR_W-1:0] sd_addr,
  input logic [BA_W-1:0]   sd_ba,
  input logic [DQM_W-1:0]  sd_dqm
);
  // R1
  masks_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !init_done |-> (&sd_dqm && !acc_allow));

  // R6
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);

  // R2
  prea_a10_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sd_cmd == CMD_PRE) |-> sd_addr[10]);

  // R5
  fullpage_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sd_cmd == CMD_MRS) |-> (!(sd_addr[3] && sd_addr[2:0] == 3'b111) && sd_ba == '0));

  // R8
  ref_after_gnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (init_done && sd_cke && sd_cmd == CMD_REF) |-> $past(ref_gnt));

  // R10
  sr_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sd_cke) |-> (sd_cmd == CMD_REF));

  // R11
  sr_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sd_cke) |-> (sd_cmd == CMD_NOP && !acc_allow));

  // R12
  allow_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_allow |-> (sd_cmd == CMD_NOP && sd_cke));
endmodule

bind sdram_refresh_seq sdr_seq_chk #(.ADDR_W(ADDR_W), .BA_W(BA_W), .DQM_W(DQM_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .ref_gnt(ref_gnt), .acc_allow(acc_allow),
  .init_done(init_done), .sd_cke(sd_cke), .sd_cmd(sd_cmd), .sd_addr(sd_addr),
  .sd_ba(sd_ba), .sd_dqm(sd_dqm)
);

// File: tb/test_sdram_refresh_seq.sv
`timescale 1ns/1ps
module test_sdram_refresh_seq;
  localparam int CLK_PERIOD = 10;
  localparam int CLKPS = 10_000;
  localparam int PWRPS = 100_000;
  localparam int TRPPS = 20_000;
  localparam int TRCPS = 55_000;
  localparam int TXSPS = 25_000;
  localparam int REFPS = 1_000_000;
  localparam int OFS   = 2;   // reset synchroniser stages
  localparam int PWRN  = (PWRPS + CLKPS - 1) / CLKPS;
  localparam int TRPN  = (TRPPS + CLKPS - 1) / CLKPS;
  localparam int TRCN  = (TRCPS + CLKPS - 1) / CLKPS;
  localparam int TXSN  = (TXSPS + CLKPS - 1) / CLKPS;
  localparam int REFN  = REFPS / CLKPS;
  localparam int P_C   = OFS + PWRN;
  localparam int R0_C  = P_C + TRPN;
  localparam int M_C   = R0_C + 8 * TRCN;
  localparam int ID_C  = M_C + 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] cfg_cas_lat = 3'd3, cfg_burst_len = 3'd0;
  logic cfg_interleave = 1'b0, cfg_single_wr = 1'b0, sr_req = 1'b0, ref_gnt = 1'b0;
  logic ref_req, acc_allow, init_done, sd_cke;
  logic [3:0] sd_cmd;
  logic [11:0] sd_addr;
  logic [1:0] sd_ba;
  logic [7:0] sd_dqm;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdram_refresh_seq #(
    .CLK_PS(CLKPS), .PWRUP_PS(PWRPS), .TRP_PS(TRPPS), .TRC_PS(TRCPS),
    .TXSR_PS(TXSPS), .TMRD_CYC(2), .REF_PERIOD_PS(REFPS), .INIT_REFS(8),
    .MAX_OWED(8), .ADDR_W(12), .BA_W(2), .DQM_W(8)
  ) i_sdram_refresh_seq (
    .clk(clk), .rst_n(rst_n), .cfg_cas_lat(cfg_cas_lat), .cfg_burst_len(cfg_burst_len),
    .cfg_interleave(cfg_interleave), .cfg_single_wr(cfg_single_wr), .sr_req(sr_req),
    .ref_gnt(ref_gnt), .ref_req(ref_req), .acc_allow(acc_allow), .init_done(init_done),
    .sd_cke(sd_cke), .sd_cmd(sd_cmd), .sd_addr(sd_addr), .sd_ba(sd_ba), .sd_dqm(sd_dqm)
  );

  typedef struct { int c; logic [3:0] cmd; logic [11:0] a; logic cke; } ev_t;
  ev_t evq[$];
  int  cyc = 0;
  int  total = 0, bad = 0;
  logic prev_cke = 1'b1;

  always @(negedge clk) begin
    if (!rst_n) begin
      cyc = 0;
      prev_cke = 1'b1;
    end else begin
      if (sd_cmd != 4'b0111 || sd_cke != prev_cke)
        evq.push_back('{c: cyc, cmd: sd_cmd, a: sd_addr, cke: sd_cke});
      prev_cke = sd_cke;
      cyc = cyc + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic at_cycle(input int b);
    while (cyc != b + 1) begin
      @(negedge clk);
      #1;
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    evq.delete();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
  endtask

  // commands of a code (with cke high) inside [lo,hi]
  task automatic exp_series(input int lo, input int hi, input logic [3:0] code,
                            input int first, input int n, input int step, input string req);
    int k = 0;
    foreach (evq[i]) begin
      if (evq[i].c >= lo && evq[i].c <= hi && evq[i].cmd == code && evq[i].cke) begin
        chk(evq[i].c == first + k * step, req, evq[i].c, first + k * step);
        k++;
      end
    end
    chk(k == n, req, k, n);
  endtask

  task automatic run_cfg(input int cl, input int bl, input bit il, input bit wb);
    int expw, bt;
    cfg_cas_lat = 3'(cl); cfg_burst_len = 3'(bl);
    cfg_interleave = il; cfg_single_wr = wb;
    do_reset();
    at_cycle(0);
    chk(sd_cke && sd_dqm == 8'hFF && sd_cmd == 4'b0111 && !init_done && !acc_allow,
        "R1 reset state", {sd_cke, sd_cmd}, 5'b10111);
    at_cycle(P_C - 1);
    chk(sd_cke && sd_dqm == 8'hFF && sd_cmd == 4'b0111, "R1 end of pause",
        {sd_cke, sd_cmd}, 5'b10111);
    at_cycle(M_C + 1);
    chk(!init_done && !acc_allow, "R6 before wait", {init_done, acc_allow}, 0);
    at_cycle(ID_C);
    chk(init_done && acc_allow && sd_dqm == 8'h00, "R6 after wait",
        {init_done, acc_allow}, 3);
    chk(evq.size() >= 10, "R2 event count", evq.size(), 10);
    if (evq.size() >= 10) begin
      chk(evq[0].c == P_C && evq[0].cmd == 4'b0010, "R2 precharge cycle", evq[0].c, P_C);
      chk(evq[0].a[10], "R2 A10", evq[0].a[10], 1);
      exp_series(0, M_C, 4'b0001, R0_C, 8, TRCN, "R3 init refresh");
      bt = (il && bl != 7) ? 1 : 0;
      expw = (int'(wb) << 9) | (cl << 4) | (bt << 3) | bl;
      chk(evq[9].c == M_C && evq[9].cmd == 4'b0000, "R4 mode write cycle", evq[9].c, M_C);
      if (il && bl == 7) chk(evq[9].a == 12'(expw), "R5 full page order", evq[9].a, expw);
      else               chk(evq[9].a == 12'(expw), "R4 mode word", evq[9].a, expw);
    end
  endtask

  initial begin
    int blv[5] = '{0, 1, 2, 3, 7};
    for (int cl = 2; cl <= 3; cl++)
      for (int b = 0; b < 5; b++)
        for (int il = 0; il < 2; il++)
          for (int wb = 0; wb < 2; wb++)
            run_cfg(cl, blv[b], il[0], wb[0]);

    // long scenario: pacing, backlog, cap, self refresh
    ref_gnt = 1'b0; sr_req = 1'b0;
    run_cfg(3, 3, 1'b0, 1'b0);
    at_cycle(ID_C + REFN - 1);
    chk(!ref_req, "R7 before first interval", ref_req, 0);
    at_cycle(ID_C + REFN);
    chk(ref_req, "R7 first interval", ref_req, 1);
    at_cycle(170); ref_gnt = 1'b1;
    at_cycle(171);
    chk(!acc_allow, "R12 busy refresh", acc_allow, 0);
    at_cycle(280); ref_gnt = 1'b0;
    exp_series(165, 280, 4'b0001, 171, 2, ID_C + 2 * REFN + 1 - 171, "R8 granted refresh");
    at_cycle(570); ref_gnt = 1'b1;
    at_cycle(600); ref_gnt = 1'b0;
    exp_series(281, 600, 4'b0001, 571, 3, TRCN, "R8 back to back");
    at_cycle(1570); ref_gnt = 1'b1;
    at_cycle(1572);
    chk(!acc_allow && ref_req, "R12 backlog busy", acc_allow, 0);
    at_cycle(1640); sr_req = 1'b1;
    exp_series(601, 1640, 4'b0001, 1571, 8, TRCN, "R9 capped backlog");
    at_cycle(1700);
    chk(!sd_cke && !acc_allow, "R10 held in self refresh", {sd_cke, acc_allow}, 0);
    begin
      int f = -1;
      foreach (evq[i]) if (evq[i].c > 1640 && evq[i].cmd == 4'b0001 && !evq[i].cke && f < 0) f = evq[i].c;
      chk(f == 1641, "R10 entry command", f, 1641);
    end
    at_cycle(1750); sr_req = 1'b0;
    at_cycle(1751);
    chk(sd_cke && sd_cmd == 4'b0111, "R11 exit cke", {sd_cke, sd_cmd}, 5'b10111);
    at_cycle(1751 + TXSN - 1);
    chk(!acc_allow, "R11 exit wait", acc_allow, 0);
    at_cycle(1751 + TXSN);
    chk(acc_allow, "R11 allow after exit", acc_allow, 1);
    ref_gnt = 1'b0;
    at_cycle(1751 + TXSN + REFN - 1);
    chk(!ref_req, "R11 interval restart early", ref_req, 0);
    at_cycle(1751 + TXSN + REFN);
    chk(ref_req, "R11 interval restart", ref_req, 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100_000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule